// File: doc/BRIEF.md
# Indexed Pixel Palette Expander

This block turns packed palette indices into 15-bit colour. Software, or a neighbouring control block, loads a 256-entry colour table through a simple write port. A stream of 32-bit words then arrives over a valid/ready handshake. Each word holds 32, 16, 8 or 4 indices, depending on the selected depth. The block slices the word into indices, starting at the least significant end. It reads the table entry for each index and presents one colour per output beat. The output also uses a valid/ready handshake, so a slow consumer can stall the stream.

The depth code is captured together with each accepted word. A single word is therefore always unpacked at one depth, even if the code changes while the word is being consumed. The table is a synchronous-read memory, so a colour appears on the output one cycle after its index is looked up.

Top module: `idx_color_expander`

## Requirements
- R1: While reset is asserted and directly after its release, `out_valid` is low and `in_ready` is high.
- R2: The table holds 256 colour entries addressed by the pixel index. `out_rgb` carries the addressed entry unchanged, with red in bits 4:0, green in bits 9:5 and blue in bits 14:10.
- R3: A table write whose 9-bit address is 256 or higher changes no entry. Later lookups of every index still return the values written below 256.
- R4: Depth code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bits per pixel, giving 32, 16, 8 and 4 pixels per word. Pixel k of a word occupies bits [k*bpp + bpp-1 : k*bpp], and pixels are emitted in increasing k.
- R5: At depth code 0 each pixel selects table entry 0 or entry 1 only. Other entries have no influence on the output.
- R6: An index taken from the unpacker produces `out_valid` high on the next cycle. When the output is idle, the first colour of a newly accepted word is valid two cycles after the accepting edge.
- R7: `in_ready` is low from the cycle after a word is accepted until the last pixel of that word has been looked up. A new word is only accepted when no pixel of the previous one is waiting.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_rgb` stays unchanged on the next cycle.
- R9: A lookup on the same edge as a write to that entry returns the old contents. Lookups on later edges return the new contents.
- R10: The depth code is sampled when a word is accepted. Changing `cfg_depth` while that word is being unpacked has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Depth code: 0=1, 1=2, 2=4, 3=8 bits per pixel |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 9 | Table write address; 256 and above are ignored |
| tbl_wdata | input | 15 | Colour to store |
| in_valid | input | 1 | Packed word valid |
| in_ready | output | 1 | Block can accept a packed word |
| in_word | input | 32 | Packed pixel indices |
| out_valid | output | 1 | Colour valid |
| out_ready | input | 1 | Consumer accepts the colour |
| out_rgb | output | 15 | Looked-up colour |

## Verification
A table write and a lookup of the same entry can fall on the same clock edge. The bench provokes this by streaming 8-bit words whose indices come from a pair of entries, while it rewrites those two entries on nearly every cycle and randomly stalls the output. The behavioural reference keeps a shadow table. At each edge it reads the shadow before applying the write, so every emitted colour is judged against the value the entry held at lookup time. Depth changes during an active word and output stalls are mixed into the same runs.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [1:0] {
    CX_BPP1 = 2'd0,
    CX_BPP2 = 2'd1,
    CX_BPP4 = 2'd2,
    CX_BPP8 = 2'd3
  } cx_depth_e;
endpackage

// File: rtl/cx_unpack.sv
module cx_unpack #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [1:0]       depth,
  output logic             in_ready,
  input  logic             take,
  output logic             idx_valid,
  output logic [IDX_W-1:0] idx
);
  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam int SHW   = $clog2(IDX_W) + 1;

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [1:0]        dep_q, dep_d;
  logic              load, en;
  logic [SHW-1:0]    bits;
  logic [IDX_W-1:0]  mask;

  assign idx_valid = (left_q != '0);
  assign in_ready  = ~idx_valid;
  assign load      = in_valid & in_ready;
  assign en        = load | take;
  assign bits      = SHW'(1) << dep_q;

  always_comb begin
    for (int i = 0; i < IDX_W; i++) mask[i] = (i < int'(bits));
  end

  assign idx = word_q[IDX_W-1:0] & mask;

  always_comb begin
    word_d = word_q;
    left_d = left_q;
    dep_d  = dep_q;
    if (load) begin
      word_d = in_word;
      left_d = CNT_W'(WORD_W >> depth);
      dep_d  = depth;
    end else if (take) begin
      word_d = word_q >> bits;
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
      dep_q  <= cx_pkg::CX_BPP1;
    end else if (en) begin
      word_q <= word_d;
      left_q <= left_d;
      dep_q  <= dep_d;
    end
  end
endmodule

// File: rtl/cx_palette.sv
module cx_palette #(
  parameter int IDX_W   = 8,
  parameter int ADDR_W  = 9,
  parameter int COLOR_W = 15
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [COLOR_W-1:0] wr_data,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [COLOR_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic               in_range;
  logic [COLOR_W-1:0] mem [DEPTH];

  generate
    if (ADDR_W > IDX_W) begin : g_range
      assign in_range = ~|wr_addr[ADDR_W-1:IDX_W];
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/cx_outctl.sv
module cx_outctl (
  input  logic clk,
  input  logic rst_n,
  input  logic idx_valid,
  input  logic out_ready,
  output logic take,
  output logic out_valid
);
  logic adv, vld_d;

  assign adv  = ~out_valid | out_ready;
  assign take = adv & idx_valid;

  always_comb begin
    vld_d = out_valid;
    if (adv) vld_d = idx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end
endmodule

// File: rtl/idx_color_expander.sv
module idx_color_expander #(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int ADDR_W  = 9,
  parameter int COLOR_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_depth,
  input  logic               tbl_we,
  input  logic [ADDR_W-1:0]  tbl_addr,
  input  logic [COLOR_W-1:0] tbl_wdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [COLOR_W-1:0] out_rgb
);
  logic             px_valid, px_take;
  logic [IDX_W-1:0] px_idx;

  cx_unpack #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .depth(cfg_depth), .in_ready(in_ready), .take(px_take),
    .idx_valid(px_valid), .idx(px_idx)
  );

  cx_palette #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_pal (
    .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
    .rd_en(px_take), .rd_idx(px_idx), .rd_data(out_rgb)
  );

  cx_outctl u_out (
    .clk(clk), .rst_n(rst_n), .idx_valid(px_valid), .out_ready(out_ready),
    .take(px_take), .out_valid(out_valid)
  );
endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
  parameter int COLOR_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               take,
  input logic [COLOR_W-1:0] out_rgb
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb)); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R7

  AST_FIRST_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !out_valid |=> ##1 out_valid); // R6

  AST_TAKE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R6

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !take |=> !out_valid); // R6
endmodule

bind idx_color_expander cx_checker #(.COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .take(px_take),
  .out_rgb(out_rgb)
);

// File: tb/tb_idx_color_expander.sv
module tb_idx_color_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_depth;
  logic        tbl_we;
  logic [8:0]  tbl_addr;
  logic [14:0] tbl_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [14:0] out_rgb;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  idx_color_expander dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb)
  );

  // behavioural reference
  int shadow [256];
  int pixq [$];
  int m_left;
  bit m_ov;
  int m_color;

  function automatic int colour_of(int i);
    return (i * 37 + 5) & 32'h7fff;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0;
      m_ov   = 0;
      pixq.delete();
    end else begin
      bit rdy;
      rdy = (m_left == 0);
      if (!m_ov || out_ready) begin
        if (m_left > 0) begin
          m_color = shadow[pixq.pop_front()];
          m_ov = 1;
          m_left--;
        end else m_ov = 0;
      end
      if (tbl_we && tbl_addr < 256) shadow[tbl_addr] = int'(tbl_wdata);
      if (rdy && in_valid) begin
        int bpp, n;
        bpp = 1 << cfg_depth;
        n   = 32 / bpp;
        for (int k = 0; k < n; k++)
          pixq.push_back(int'((in_word >> (k * bpp)) & ((32'd1 << bpp) - 1)));
        m_left = n;
      end
    end
  end

  task automatic check(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    check(out_valid === m_ov, {"R6 ", tag}, "out_valid", int'(out_valid), int'(m_ov));
    check(in_ready === (m_left == 0), {"R7 ", tag}, "in_ready", int'(in_ready), int'(m_left == 0));
    if (m_ov)
      check(out_rgb === m_color[14:0], {"R2 ", tag}, "out_rgb", int'(out_rgb), m_color);
  endtask

  // mode: 0 free, 1 fixed word 44s, 2 stall, 3 depth churn, 4 concurrent writes
  task automatic run(int cycles, int mode, int depth);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      tbl_we    = 1'b0;
      in_valid  = ($urandom_range(0, 3) != 0);
      in_word   = $urandom();
      out_ready = 1'b1;
      cfg_depth = 2'(depth);
      case (mode)
        1: in_word = 32'h2C2C2C2C;
        2: out_ready = $urandom_range(0, 1) == 1;
        3: begin
          cfg_depth = 2'($urandom_range(0, 3));
          out_ready = $urandom_range(0, 3) != 0;
        end
        4: begin
          in_word   = $urandom() & 32'h01010101 | 32'h10101010;
          out_ready = $urandom_range(0, 2) != 0;
          tbl_we    = $urandom_range(0, 4) != 0;
          tbl_addr  = 9'h010 + 9'($urandom_range(0, 1));
          tbl_wdata = 15'($urandom());
        end
        default: ;
      endcase
    end
  endtask

  task automatic drain();
    in_valid = 1'b0;
    out_ready = 1'b1;
    tbl_we = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_depth = 2'd0; tbl_we = 1'b0; tbl_addr = '0;
    tbl_wdata = '0; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // load the table, then two out-of-range writes (R3)
    for (int i = 0; i < 256; i++) begin
      tbl_we = 1'b1; tbl_addr = 9'(i); tbl_wdata = 15'(colour_of(i));
      @(negedge clk);
    end
    tbl_addr = 9'd300; tbl_wdata = 15'(~colour_of(44));
    @(negedge clk);
    tbl_addr = 9'd511; tbl_wdata = 15'h7fff;
    @(negedge clk);
    tbl_we = 1'b0;

    // R6 directed timing: one 8-bit word, idle output
    tag = "R6";
    cfg_depth = 2'd3; in_word = 32'h04030201; in_valid = 1'b1;
    @(negedge clk);
    compare();
    in_valid = 1'b0;
    check(out_valid === 1'b0, "R6", "valid one cycle after accept", int'(out_valid), 0);
    check(in_ready === 1'b0, "R7", "busy after accept", int'(in_ready), 0);
    @(negedge clk);
    check(out_valid === 1'b1, "R6", "valid two cycles after accept", int'(out_valid), 1);
    check(out_rgb === 15'(colour_of(1)), "R4", "first pixel LSB", int'(out_rgb), colour_of(1));
    compare();
    drain();

    tag = "R3";
    run(60, 1, 3);
    drain();
    check(shadow[44] == colour_of(44), "R3", "entry 44 kept", shadow[44], colour_of(44));

    tag = "R5 R4";
    run(300, 0, 0);
    drain();
    for (int d = 1; d < 4; d++) begin
      tag = "R2 R4";
      run(300, 0, d);
      drain();
    end

    tag = "R8";
    run(800, 2, 3);
    run(800, 2, 1);
    drain();

    tag = "R10";
    run(1500, 3, 0);
    drain();

    tag = "R9";
    run(1500, 4, 3);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule